// File: doc/BRIEF.md
# Parallel-port host-to-peripheral bridge

This block lets a personal computer acting as an enhanced parallel port host read and write a local peripheral. The host always starts the cycle by pulling its address strobe or data strobe low, with its write line saying the direction. The bridge has one clock domain, so each host line passes through a two-flop synchronizer before the control logic uses it. The bridge then runs the matching cycle on a simple processor-style bus and answers the host by raising its wait/acknowledge line.

An address-strobe cycle touches only the bridge's own 8-bit address register. A host write loads the register and a host read returns it. A data-strobe cycle reaches the peripheral at the held address. The peripheral side is interlocked. The bridge waits for the peripheral's ready flag before it gives a one-clock read or write strobe. On reads it also waits for the data-valid reply before it acknowledges the host. A slow peripheral can therefore stretch any host cycle. Host data travels on separate in and out buses, and an output-enable tells the surrounding logic when to drive the shared pins.

Top module: `epp_slave_bridge`

## Requirements
- R1: While reset is held and just after it, host_wait_o, host_data_oe_o, per_rd_o and per_wr_o are 0 and per_addr_o is 0x00.
- R2: A host write with the address strobe (host_astb_ni low, host_write_ni low) loads host_data_i into the address register, which appears on per_addr_o. It produces no per_rd_o or per_wr_o pulse.
- R3: A host read with the address strobe returns the address register on host_data_o, with host_data_oe_o high while host_wait_o is high.
- R4: A host write with the data strobe gives exactly one single-clock per_wr_o pulse. per_wdata_o carries the host data and per_addr_o the address register. The pulse comes only after per_ready_i was sampled high.
- R5: A host read with the data strobe gives exactly one single-clock per_rd_o pulse, only after per_ready_i was sampled high. per_rd_o and per_wr_o are never high together.
- R6: On a data read, host_wait_o rises only after per_valid_i has been sampled high following the read pulse, and host_data_o then holds the per_rdata_i value sampled at that moment.
- R7: While per_ready_i is held low, or per_valid_i is held low after a read pulse, host_wait_o stays low. No strobe is issued while host_wait_o is high.
- R8: Once raised, host_wait_o stays high for as long as a host strobe is held low. It falls only after both strobes were seen released, and host_data_oe_o is low when it falls.
- R9: host_data_oe_o is high only while host_wait_o is high in a read cycle. It is never high in a write cycle.
- R10: A host that starts its next strobe without waiting for host_wait_o to fall is served correctly, provided each strobe release lasts at least two clock periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_write_ni | input | 1 | Host direction, low for write |
| host_dstb_ni | input | 1 | Host data strobe, active low |
| host_astb_ni | input | 1 | Host address strobe, active low |
| host_data_i | input | 8 | Data from host |
| host_data_o | output | 8 | Data to host |
| host_data_oe_o | output | 1 | Enable for the host data pad drivers |
| host_wait_o | output | 1 | Wait/acknowledge to host |
| per_addr_o | output | 8 | Peripheral address |
| per_wdata_o | output | 8 | Peripheral write data |
| per_rdata_i | input | 8 | Peripheral read data |
| per_rd_o | output | 1 | Single-clock read strobe |
| per_wr_o | output | 1 | Single-clock write strobe |
| per_ready_i | input | 1 | Peripheral ready to accept a strobe |
| per_valid_i | input | 1 | Peripheral read data valid |

## Verification
The checker verifies the following on every cycle:
- each strobe is gated by ready and lasts one clock;
- the two strobes never overlap;
- no strobe occurs during an acknowledge;
- the acknowledge never directly follows a read pulse;
- the acknowledge falls only after a synchronized strobe release, with the enable already low;
- the enable only appears during an acknowledge.

Only the bench's scenarios can show the data paths. These cover address load and readback, write data and address on the peripheral bus, and read data against a reference memory. The scenarios also cover long ready and valid stalls, held host strobes, and back-to-back cycles from a host that does not wait for the acknowledge to fall.

// File: rtl/epp_pkg.sv
package epp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_W_RDY, ST_W_STB, ST_R_RDY, ST_R_STB, ST_R_VAL, ST_ACK
  } epp_state_e;
endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/epp_ctrl.sv
module epp_ctrl
  import epp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              astb_i,   // synchronized, active high
  input  logic              dstb_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] host_data_i,
  output logic [DATA_W-1:0] host_data_o,
  output logic              host_data_oe_o,
  output logic              host_wait_o,
  output logic [DATA_W-1:0] per_addr_o,
  output logic [DATA_W-1:0] per_wdata_o,
  input  logic [DATA_W-1:0] per_rdata_i,
  output logic              per_rd_o,
  output logic              per_wr_o,
  input  logic              per_ready_i,
  input  logic              per_valid_i
);
  epp_state_e        state_q;
  logic [DATA_W-1:0] addr_q, wdata_q, rdata_q;
  logic              oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (astb_i) begin
            if (wr_i) addr_q <= host_data_i;
            else begin
              rdata_q <= addr_q;
              oe_q    <= 1'b1;
            end
            state_q <= ST_ACK;
          end else if (dstb_i) begin
            if (wr_i) begin
              wdata_q <= host_data_i;
              state_q <= ST_W_RDY;
            end else begin
              state_q <= ST_R_RDY;
            end
          end
        end
        ST_W_RDY: if (per_ready_i) state_q <= ST_W_STB;
        ST_W_STB: state_q <= ST_ACK;
        ST_R_RDY: if (per_ready_i) state_q <= ST_R_STB;
        ST_R_STB: state_q <= ST_R_VAL;
        ST_R_VAL: begin
          if (per_valid_i) begin
            rdata_q <= per_rdata_i;
            oe_q    <= 1'b1;
            state_q <= ST_ACK;
          end
        end
        ST_ACK: begin
          // hold acknowledge until the host releases both strobes
          if (!astb_i && !dstb_i) begin
            oe_q    <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign host_wait_o    = (state_q == ST_ACK);
  assign host_data_oe_o = oe_q;
  assign host_data_o    = rdata_q;
  assign per_addr_o     = addr_q;
  assign per_wdata_o    = wdata_q;
  assign per_rd_o       = (state_q == ST_R_STB);
  assign per_wr_o       = (state_q == ST_W_STB);
endmodule

// File: rtl/epp_slave_bridge.sv
module epp_slave_bridge #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_write_ni,
  input  logic              host_dstb_ni,
  input  logic              host_astb_ni,
  input  logic [DATA_W-1:0] host_data_i,
  output logic [DATA_W-1:0] host_data_o,
  output logic              host_data_oe_o,
  output logic              host_wait_o,
  output logic [DATA_W-1:0] per_addr_o,
  output logic [DATA_W-1:0] per_wdata_o,
  input  logic [DATA_W-1:0] per_rdata_i,
  output logic              per_rd_o,
  output logic              per_wr_o,
  input  logic              per_ready_i,
  input  logic              per_valid_i
);
  localparam int N_CTRL = 3;

  logic [N_CTRL-1:0] ctrl_n_s;
  logic              strb_idle;

  epp_sync #(.WIDTH(N_CTRL), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({host_write_ni, host_dstb_ni, host_astb_ni}),
    .q_o    (ctrl_n_s)
  );

  assign strb_idle = ctrl_n_s[1] & ctrl_n_s[0];

  epp_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .astb_i         (~ctrl_n_s[0]),
    .dstb_i         (~ctrl_n_s[1]),
    .wr_i           (~ctrl_n_s[2]),
    .host_data_i    (host_data_i),
    .host_data_o    (host_data_o),
    .host_data_oe_o (host_data_oe_o),
    .host_wait_o    (host_wait_o),
    .per_addr_o     (per_addr_o),
    .per_wdata_o    (per_wdata_o),
    .per_rdata_i    (per_rdata_i),
    .per_rd_o       (per_rd_o),
    .per_wr_o       (per_wr_o),
    .per_ready_i    (per_ready_i),
    .per_valid_i    (per_valid_i)
  );
endmodule

// File: rtl/epp_slave_checker.sv
module epp_slave_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic per_rd_o,
  input logic per_wr_o,
  input logic per_ready_i,
  input logic host_wait_o,
  input logic host_data_oe_o,
  input logic strb_idle
);
  AST_WR_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_wr_o |-> $past(per_ready_i)); // R4
  AST_WR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_wr_o |=> !per_wr_o); // R4
  AST_RD_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_rd_o |-> $past(per_ready_i)); // R5
  AST_RD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_rd_o |=> !per_rd_o); // R5
  AST_STROBES_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(per_rd_o && per_wr_o)); // R5
  AST_NO_EARLY_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_rd_o |=> !host_wait_o); // R6
  AST_NO_STB_IN_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wait_o |-> (!per_rd_o && !per_wr_o)); // R7
  AST_ACK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(host_wait_o) |-> $past(strb_idle)); // R8
  AST_OE_OFF_AT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(host_wait_o) |-> !host_data_oe_o); // R8
  AST_OE_IN_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_data_oe_o |-> host_wait_o); // R9
endmodule

bind epp_slave_bridge epp_slave_checker u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .per_rd_o       (per_rd_o),
  .per_wr_o       (per_wr_o),
  .per_ready_i    (per_ready_i),
  .host_wait_o    (host_wait_o),
  .host_data_oe_o (host_data_oe_o),
  .strb_idle      (strb_idle)
);

// File: tb/epp_slave_bridge_tb.sv
module epp_slave_bridge_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 0, rst_ni = 0;
  logic       host_write_ni = 1, host_dstb_ni = 1, host_astb_ni = 1;
  logic [7:0] host_data_i = 0, host_data_o, per_addr_o, per_wdata_o;
  logic [7:0] per_rdata_i = 0;
  logic       host_data_oe_o, host_wait_o, per_rd_o, per_wr_o;
  logic       per_ready_i = 0, per_valid_i = 0;

  int checks = 0, errors = 0;
  int wr_cnt = 0, rd_cnt = 0;
  bit hold_ready = 0, hold_valid = 0;
  logic [7:0] ref_mem [256];
  logic [7:0] per_mem [256];
  logic [7:0] ref_addr = 0, exp_wdata = 0;
  int   vdly = -1;
  bit   done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  epp_slave_bridge u_dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input bit is_addr);
    return is_addr ? ref_addr : ref_mem[ref_addr];
  endfunction

  // peripheral model, driven away from the active edge
  always @(negedge clk_i) begin
    if (per_wr_o) begin
      wr_cnt++;
      chk(per_addr_o == ref_addr, "R4", "write address", per_addr_o, ref_addr);
      chk(per_wdata_o == exp_wdata, "R4", "write data", per_wdata_o, exp_wdata);
      per_mem[per_addr_o] = per_wdata_o;
    end
    if (per_rd_o) begin
      rd_cnt++;
      per_rdata_i = per_mem[per_addr_o];
      vdly = int'($urandom % 4);
    end
    if (host_wait_o) per_valid_i = 0;
    else if (vdly == 0 && !hold_valid) begin
      per_valid_i = 1;
      vdly = -1;
    end else if (vdly > 0) vdly--;
    per_ready_i = hold_ready ? 1'b0 : (($urandom % 4) != 0);
  end

  task automatic wait_ack(output bit ok);
    int t = 0;
    while (!host_wait_o && t < 2000) begin @(negedge clk_i); t++; end
    ok = host_wait_o;
  endtask

  // one host cycle; fast=1 releases for two clocks and does not wait for ack to drop
  task automatic host_cycle(input bit is_addr, input bit is_wr, input logic [7:0] d,
                            input bit fast);
    bit ok;
    logic [7:0] e;
    int w0 = wr_cnt, r0 = rd_cnt;
    @(negedge clk_i);
    host_data_i = d; host_write_ni = !is_wr;
    if (is_wr && !is_addr) exp_wdata = d;
    @(negedge clk_i);
    if (is_addr) host_astb_ni = 0; else host_dstb_ni = 0;
    @(negedge clk_i);
    wait_ack(ok);
    chk(ok, fast ? "R10" : "R8", "acknowledge reached", {7'b0, host_wait_o}, 8'h01);
    chk(host_data_oe_o == !is_wr, "R9", "output enable in ack", {7'b0, host_data_oe_o},
        {7'b0, !is_wr});
    if (!is_wr) begin
      e = exp_read(is_addr);
      chk(host_data_o == e, is_addr ? "R3" : "R6", "read data", host_data_o, e);
    end
    if (is_wr && is_addr) begin
      ref_addr = d;
      @(negedge clk_i);
      chk(per_addr_o == d, "R2", "address register", per_addr_o, d);
    end
    if (is_wr && !is_addr) ref_mem[ref_addr] = d;
    if (is_addr)
      chk(wr_cnt == w0 && rd_cnt == r0, "R2", "no strobe on address cycle",
          8'(wr_cnt - w0 + rd_cnt - r0), 8'h00);
    else if (is_wr)
      chk(wr_cnt == w0 + 1 && rd_cnt == r0, "R4", "one write pulse", 8'(wr_cnt - w0), 8'h01);
    else
      chk(rd_cnt == r0 + 1 && wr_cnt == w0, "R5", "one read pulse", 8'(rd_cnt - r0), 8'h01);
    @(negedge clk_i);
    host_astb_ni = 1; host_dstb_ni = 1;
    if (!fast) begin
      int t = 0;
      while (host_wait_o && t < 50) begin @(negedge clk_i); t++; end
      chk(!host_wait_o && !host_data_oe_o, "R8", "release drops ack and enable",
          {6'b0, host_wait_o, host_data_oe_o}, 8'h00);
    end
  endtask

  initial begin
    bit ok;
    for (int i = 0; i < 256; i++) begin ref_mem[i] = 0; per_mem[i] = 0; end
    repeat (3) @(negedge clk_i);
    chk(!host_wait_o && !host_data_oe_o && !per_rd_o && !per_wr_o, "R1", "outputs in reset",
        {4'b0, host_wait_o, host_data_oe_o, per_rd_o, per_wr_o}, 8'h00);
    rst_ni = 1;
    @(negedge clk_i);
    chk(per_addr_o == 8'h00 && !host_wait_o, "R1", "state after reset", per_addr_o, 8'h00);

    // directed: address load and readback
    host_cycle(1, 1, 8'hA5, 0);
    host_cycle(1, 0, 8'h00, 0);
    host_cycle(0, 1, 8'h3C, 0);
    host_cycle(0, 0, 8'h00, 0);

    // R7: ready stall on a write
    hold_ready = 1;
    @(negedge clk_i);
    host_data_i = 8'h77; host_write_ni = 0; exp_wdata = 8'h77;
    @(negedge clk_i); host_dstb_ni = 0;
    repeat (20) @(negedge clk_i);
    chk(!host_wait_o && wr_cnt == 1, "R7", "ready stall holds ack and strobe",
        {7'b0, host_wait_o}, 8'h00);
    hold_ready = 0;
    @(negedge clk_i);
    wait_ack(ok);
    chk(ok && wr_cnt == 2, "R7", "write completes after ready", 8'(wr_cnt), 8'h02);
    ref_mem[ref_addr] = 8'h77;
    // R8: strobe held long after ack
    repeat (10) @(negedge clk_i);
    chk(host_wait_o, "R8", "ack held while strobe low", {7'b0, host_wait_o}, 8'h01);
    host_dstb_ni = 1;
    repeat (5) @(negedge clk_i);
    chk(!host_wait_o, "R8", "ack dropped after release", {7'b0, host_wait_o}, 8'h00);

    // R7/R6: valid stall on a read
    hold_valid = 1;
    @(negedge clk_i); host_write_ni = 1;
    @(negedge clk_i); host_dstb_ni = 0;
    repeat (20) @(negedge clk_i);
    chk(!host_wait_o && rd_cnt == 2, "R7", "valid stall holds ack", {7'b0, host_wait_o}, 8'h00);
    hold_valid = 0;
    wait_ack(ok);
    chk(ok && host_data_o == 8'h77, "R6", "read after valid stall", host_data_o, 8'h77);
    @(negedge clk_i); host_dstb_ni = 1;
    repeat (5) @(negedge clk_i);

    // random mix, both host timing styles
    for (int n = 0; n < 80; n++) begin
      int op = int'($urandom % 4);
      bit fast = ($urandom % 2) == 1;
      logic [7:0] d = 8'($urandom);
      if (op == 0) host_cycle(1, 1, d % 8, fast);
      else host_cycle(op == 3, op != 2, d, fast);
    end
    repeat (5) @(negedge clk_i);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule